// File: doc/BRIEF.md
# Programmable Periodic Timebase Interrupt Generator

This block divides a crystal-derived clock with a free-running binary counter and raises a sticky event flag each time the selected period elapses. The period is chosen from an eight-entry table of non-uniform powers of two by a 3-bit rate code. A prescale bit multiplies every entry by 128. Software drives the block through a single 8-bit register port: one write strobe with write data, plus combinational read data. Through this port it enables the counter, picks the rate, arms the interrupt and acknowledges the flag. The block drives an interrupt request whenever the flag and the interrupt enable are both set.

The block follows the chip's low-power states. In the wait state the counter keeps running, but the register port is closed. In the stop state the counter runs only when the system allows the oscillator to keep running while stopped; otherwise the counter holds its value. While stopped, every elapsed period also produces a one-cycle wakeup pulse, so the block can act as a periodic alarm that brings the chip out of stop.

Top module: `tbg_timebase`

## Requirements
- R1: After synchronous reset the enable, interrupt enable, prescale, rate code and flag are all zero, so `reg_rdata` reads 0 and `irq` and `wake_req` are low.
- R2: Register layout for both write and read: bit 0 enable, bit 1 interrupt enable, bit 2 prescale, bits 5:3 rate code. Bit 6 reads the flag. Bit 7 written as 1 is an acknowledge. With prescale clear, rate codes 0 to 7 give periods of 32768, 8192, 2048, 128, 64, 32, 16 and 8 clocks.
- R3: With prescale set, each period from R2 is multiplied by 128, for example code 3 gives 16384 clocks and code 7 gives 1024 clocks.
- R4: While disabled, the counter is held at zero. The first flag after the write that sets enable appears exactly one full period after that write, even if the block was just enabled and disabled again.
- R5: Each time the period elapses the flag is set and stays set. `irq` is high exactly when the flag and the interrupt enable are both set.
- R6: A write with bit 7 set clears the flag. If a period ends on the same clock edge as that write, the flag stays set.
- R7: While enable is set, writes leave the rate code and prescale bit unchanged, but they still update enable and interrupt enable. The period in force does not change.
- R8: With `wait_mode` high, counting continues and flags are still raised. Writes have no effect and `reg_rdata` reads 0.
- R9: With `stop_mode` high and `osc_in_stop` low, the counter holds its value. Counting resumes from the held value when stop ends, so the next flag is late by exactly the number of stopped cycles.
- R10: With `stop_mode` and `osc_in_stop` both high, counting continues. The register port is blocked as in R8. Each period that ends while stopped raises `wake_req` for exactly one cycle, together with the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-derived clock that the divider counts |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data: control fields and acknowledge bit |
| reg_rdata | output | 8 | Read data: control fields and flag, 0 when the port is blocked |
| wait_mode | input | 1 | Chip is in the wait low-power state |
| stop_mode | input | 1 | Chip is in the stop low-power state |
| osc_in_stop | input | 1 | System configuration: oscillator keeps running in stop |
| irq | output | 1 | Interrupt request (flag AND interrupt enable) |
| wake_req | output | 1 | One-cycle wakeup pulse for a period that ends in stop |

## Verification
The assertions assume `wait_mode`, `stop_mode` and `osc_in_stop` are synchronous to `clk` and settle between edges. They also assume a write strobe lasts one cycle and is not held across a mode change. The bench drives every input on the falling edge and pulses `reg_we` for one cycle only. It changes the mode inputs only while no write is pending, and it leaves stop or wait before issuing the acknowledge that clears a flag raised during those states. Rate changes while enabled are attempted on purpose, so that their rejection can be observed through read data and through the unchanged period.

// File: rtl/tbg_pkg.sv
// Shared constants, register field positions and the rate-code to
// divider-exponent mapping for the periodic timebase.
// Assumes every divider is a power of two, so a period is a mask test.
package tbg_pkg;
    localparam int RATE_W       = 3;
    localparam int PRE_SHIFT    = 7;   // extra divide-by-128 stage
    localparam int BASE_MAX_EXP = 15;  // largest base divider is 2^15
    localparam int CNT_W        = BASE_MAX_EXP + PRE_SHIFT;
    localparam int EXP_W        = $clog2(CNT_W + 1);
    localparam int REG_W        = 8;

    // Register field positions, shared by write and read data.
    localparam int F_EN      = 0;
    localparam int F_IE      = 1;
    localparam int F_PRE     = 2;
    localparam int F_RATE_LO = 3;
    localparam int F_FLAG    = 6;
    localparam int F_ACK     = 7;

    typedef logic [EXP_W-1:0] exp_t;

    typedef struct packed {
        logic              enable;
        logic              ie;
        logic              pre;
        logic [RATE_W-1:0] rate;
    } cfg_t;

    // Base divider exponent per rate code (non-uniform table).
    function automatic exp_t base_exp(input logic [RATE_W-1:0] code);
        case (code)
            3'd0:    return exp_t'(15);
            3'd1:    return exp_t'(13);
            3'd2:    return exp_t'(11);
            3'd3:    return exp_t'(7);
            3'd4:    return exp_t'(6);
            3'd5:    return exp_t'(5);
            3'd6:    return exp_t'(4);
            default: return exp_t'(3);
        endcase
    endfunction
endpackage

// File: rtl/tbg_regs.sv
// Register port of the timebase: holds the control fields, decodes the
// acknowledge strobe and forms read data.
// Assumes 'blocked' is high in any low-power state; a blocked write is
// dropped and a blocked read returns zero.
module tbg_regs
    import tbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    input  logic             blocked,
    input  logic             flag,
    output cfg_t             cfg,
    output logic             ack,
    output logic [REG_W-1:0] rdata
);
    logic wr_ok;

    // Purpose: accept a write only when the port is open.
    always_comb wr_ok = we & ~blocked;

    // Purpose: update control fields; rate and prescale only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_ok) begin
            cfg.enable <= wdata[F_EN];
            cfg.ie     <= wdata[F_IE];
            if (!cfg.enable) begin
                cfg.pre  <= wdata[F_PRE];
                cfg.rate <= wdata[F_RATE_LO +: RATE_W];
            end
        end
    end

    // Purpose: one-cycle acknowledge toward the flag logic.
    always_comb ack = wr_ok & wdata[F_ACK];

    // Purpose: read data, forced to zero while the port is blocked.
    always_comb begin
        rdata = '0;
        if (!blocked) begin
            rdata[F_EN]                 = cfg.enable;
            rdata[F_IE]                 = cfg.ie;
            rdata[F_PRE]                = cfg.pre;
            rdata[F_RATE_LO +: RATE_W]  = cfg.rate;
            rdata[F_FLAG]               = flag;
        end
    end

    AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.enable |=> ($stable(cfg.rate) && $stable(cfg.pre))); // R7
    AST_PORT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> $stable(cfg)); // R8
endmodule

// File: rtl/tbg_divider.sv
// Free-running binary divider. It is cleared while disabled, holds its
// value while 'run' is low, and pulses 'tick' on the clock edge that
// completes a period of 2^shamt counting cycles.
// Assumes shamt <= CNT_W.
module tbg_divider #(
    parameter int CNT_W = tbg_pkg::CNT_W,
    parameter int EXP_W = tbg_pkg::EXP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic [EXP_W-1:0] shamt,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] mask;

    // Purpose: low-order mask covering the selected divider width.
    always_comb mask = ~({CNT_W{1'b1}} << shamt);

    // Purpose: count while enabled and running; clear while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (!enable) cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
    end

    // Purpose: terminal count of the selected low-order field.
    always_comb tick = enable & run & ((cnt & mask) == mask);

    AST_HOLD_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !run) |=> $stable(cnt)); // R9
    AST_CLEAR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (cnt == '0)); // R4
endmodule

// File: rtl/tbg_flag.sv
// Sticky event flag, interrupt request and stop-mode wakeup pulse.
// Assumes 'ack' is a single-cycle strobe; a tick on the same edge wins.
module tbg_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ack,
    input  logic ie,
    input  logic stop,
    output logic flag,
    output logic irq,
    output logic wake
);
    // Purpose: set on tick, clear on acknowledge, tick has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (tick) flag <= 1'b1;
        else if (ack)  flag <= 1'b0;
    end

    // Purpose: one-cycle wakeup for a period ending during stop.
    always_ff @(posedge clk) begin
        if (!rst_n) wake <= 1'b0;
        else        wake <= tick & stop;
    end

    // Purpose: request an interrupt while the flag is armed.
    always_comb irq = flag & ie;

    AST_TICK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> flag); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !tick) |=> !flag); // R6
    AST_WAKE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> flag); // R10
    AST_WAKE_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(stop)); // R10
endmodule

// File: rtl/tbg_timebase.sv
// Top of the periodic timebase. It combines the register port, the
// divider and the flag logic, and applies the low-power gating.
// Assumes the mode inputs are synchronous to clk.
module tbg_timebase
    import tbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             wait_mode,
    input  logic             stop_mode,
    input  logic             osc_in_stop,
    output logic             irq,
    output logic             wake_req
);
    cfg_t cfg;
    logic ack, tick, flag, blocked, run;
    exp_t shamt;

    // Purpose: the port closes in either low-power state.
    always_comb blocked = wait_mode | stop_mode;

    // Purpose: the clock stops in stop mode unless the oscillator is kept.
    always_comb run = ~stop_mode | osc_in_stop;

    // Purpose: divider exponent from the rate code and prescale stage.
    always_comb shamt = base_exp(cfg.rate) + (cfg.pre ? exp_t'(PRE_SHIFT) : exp_t'(0));

    tbg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .wdata   (reg_wdata),
        .blocked (blocked),
        .flag    (flag),
        .cfg     (cfg),
        .ack     (ack),
        .rdata   (reg_rdata)
    );

    tbg_divider #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (cfg.enable),
        .run    (run),
        .shamt  (shamt),
        .tick   (tick)
    );

    tbg_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .ack   (ack),
        .ie    (cfg.ie),
        .stop  (stop_mode),
        .flag  (flag),
        .irq   (irq),
        .wake  (wake_req)
    );

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cfg.ie); // R5
    AST_NO_WAKE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode |=> !wake_req); // R10
endmodule

// File: tb/sim_tbg_timebase.sv
// Scoreboard bench: the driver queues the expected cycle of each interrupt
// rise, and a monitor pops and compares on every observed rise.
module sim_tbg_timebase;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       wait_mode = 1'b0;
    logic       stop_mode = 1'b0;
    logic       osc_in_stop = 1'b0;
    logic       irq;
    logic       wake_req;

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;  // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    tbg_timebase u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wait_mode(wait_mode), .stop_mode(stop_mode),
        .osc_in_stop(osc_in_stop), .irq(irq), .wake_req(wake_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at cyc=%0d", req, act, expv, cyc);
        end
    endtask

    function automatic logic [7:0] cfg(input bit en, input bit ie, input bit pre,
                                       input logic [2:0] rate, input bit ack);
        return {ack, 1'b0, rate, pre, ie, en};
    endfunction

    function automatic int next_rise(input int e, input int div, input int now);
        return e + div * ((now - e) / div + 1);
    endfunction

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic push(input int c, input string t);
        exp_q.push_back(c);
        tag_q.push_back(t);
    endtask

    task automatic wait_irq();
        while (!irq) @(negedge clk);
    endtask

    task automatic run_periods(input logic [2:0] rate, input bit pre, input int div,
                               input int n, input string t);
        int e;
        wr(cfg(1, 1, pre, rate, 0));
        e = cyc;
        for (int i = 0; i < n; i++) begin
            push(next_rise(e, div, cyc), t);
            wait_irq();
            if (i == n - 1) wr(cfg(0, 0, 0, 0, 1));
            else            wr(cfg(1, 1, pre, rate, 1));
        end
    endtask

    // Monitor: compare the cycle of each interrupt rise with the queue.
    initial begin
        logic prev;
        prev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && irq && !prev) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected irq rise", cyc, -1);
                end else begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(cyc == e, t, cyc, e);
                end
            end
            prev = irq;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            chk(1'b0, "watchdog", cyc, 200000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int e, a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(reg_rdata == 8'h00, "R1 rdata", reg_rdata, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(wake_req == 1'b0, "R1 wake", wake_req, 0);

        // R2/R5/R6/R7: period 8, sticky flag, acknowledge, rate write ignored
        wr(cfg(1, 1, 0, 3'd7, 0));
        e = cyc;
        push(e + 8, "R2 code7");
        wait_irq();
        chk(reg_rdata[6] == 1'b1, "R5 flag set", reg_rdata[6], 1);
        chk(wake_req == 1'b0, "R10 no wake when awake", wake_req, 0);
        wr(cfg(1, 1, 0, 3'd7, 1));
        chk(irq == 1'b0, "R6 ack clears", irq, 0);
        push(next_rise(e, 8, cyc), "R7 period kept");
        wr(cfg(1, 1, 1, 3'd0, 0));
        chk(reg_rdata[5:3] == 3'd7, "R7 rate held", reg_rdata[5:3], 7);
        chk(reg_rdata[2] == 1'b0, "R7 prescale held", reg_rdata[2], 0);
        wait_irq();
        wr(cfg(0, 0, 0, 0, 1));

        // R2/R3: further table entries
        run_periods(3'd3, 1'b0, 128, 2, "R2 code3");
        run_periods(3'd0, 1'b0, 32768, 1, "R2 code0");
        run_periods(3'd7, 1'b1, 1024, 2, "R3 code7 pre");
        run_periods(3'd3, 1'b1, 16384, 1, "R3 code3 pre");
        run_periods(3'd5, 1'b1, 4096, 1, "R3 code5 pre");

        // R4: disabling clears the divider; re-enable gives a full period
        wr(cfg(1, 1, 0, 3'd7, 0));
        repeat (5) @(negedge clk);
        wr(cfg(0, 1, 0, 3'd7, 0));
        wr(cfg(1, 1, 0, 3'd7, 0));
        e = cyc;
        push(e + 8, "R4 full first period");
        wait_irq();
        wr(cfg(0, 0, 0, 0, 1));

        // R5: flag without interrupt enable gives no request
        wr(cfg(1, 0, 0, 3'd7, 0));
        e = cyc;
        while (cyc < e + 9) @(negedge clk);
        chk(reg_rdata[6] == 1'b1, "R5 flag with ie clear", reg_rdata[6], 1);
        chk(irq == 1'b0, "R5 irq masked", irq, 0);
        wr(cfg(0, 0, 0, 3'd7, 1));
        chk(reg_rdata[6] == 1'b0, "R6 ack with ie clear", reg_rdata[6], 0);

        // R6: acknowledge on the same edge as a tick keeps the flag
        wr(cfg(1, 1, 0, 3'd7, 0));
        e = cyc;
        push(e + 8, "R6 first");
        wait_irq();
        wr(cfg(1, 1, 0, 3'd7, 1));
        push(e + 16, "R6 second");
        while (cyc < e + 15) @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = cfg(1, 1, 0, 3'd7, 1);
        @(negedge clk);
        reg_we = 1'b0;
        chk(reg_rdata[6] == 1'b1, "R6 tick beats ack", reg_rdata[6], 1);
        @(negedge clk);
        chk(irq == 1'b1, "R6 flag still set", irq, 1);
        wr(cfg(0, 0, 0, 0, 1));

        // R8: wait mode keeps counting, blocks writes and reads
        wr(cfg(1, 1, 0, 3'd7, 0));
        e = cyc;
        push(e + 8, "R8 counts in wait");
        @(negedge clk);
        wait_mode = 1'b1;
        #1;
        chk(reg_rdata == 8'h00, "R8 read blocked", reg_rdata, 0);
        wr(cfg(0, 0, 0, 3'd0, 0));
        wait_irq();
        wr(cfg(1, 1, 0, 3'd7, 1));
        chk(irq == 1'b1, "R8 ack blocked", irq, 1);
        wait_mode = 1'b0;
        #1;
        chk(reg_rdata[0] == 1'b1, "R8 write blocked", reg_rdata[0], 1);
        wr(cfg(0, 0, 0, 0, 1));

        // R9: stop without oscillator freezes the count for 40 cycles
        wr(cfg(1, 1, 0, 3'd7, 0));
        e = cyc;
        push(e + 48, "R9 delayed by stop");
        @(negedge clk);
        stop_mode = 1'b1;
        repeat (40) @(negedge clk);
        chk(irq == 1'b0, "R9 frozen", irq, 0);
        chk(wake_req == 1'b0, "R9 no wake", wake_req, 0);
        stop_mode = 1'b0;
        wait_irq();
        wr(cfg(0, 0, 0, 0, 1));

        // R10: stop with oscillator keeps counting and pulses wake
        osc_in_stop = 1'b1;
        wr(cfg(1, 1, 0, 3'd7, 0));
        e = cyc;
        push(e + 8, "R10 counts in stop");
        @(negedge clk);
        stop_mode = 1'b1;
        wait_irq();
        chk(wake_req == 1'b1, "R10 wake asserted", wake_req, 1);
        @(negedge clk);
        chk(wake_req == 1'b0, "R10 wake one cycle", wake_req, 0);
        chk(reg_rdata == 8'h00, "R10 read blocked", reg_rdata, 0);
        wr(cfg(1, 1, 0, 3'd7, 1));
        chk(irq == 1'b1, "R10 ack blocked", irq, 1);
        a = cyc;
        stop_mode = 1'b0;
        osc_in_stop = 1'b0;
        wr(cfg(0, 0, 0, 0, 1));
        chk(irq == 1'b0, "R10 ack after stop", irq, a - a);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all rises seen", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule